// File: doc/BRIEF.md
# Peripheral Identifier Tree Lookup

This block turns a 12-bit peripheral identifier into an 8-bit slot number. The identifier is the 4-bit slave number placed above the 8-bit peripheral number (`slave << 8 | peripheral`). The translation walks a binary decision tree held in a local table of node words. Each node names one identifier bit to test. Each of its two branches either points to another node or ends the walk with a slot number.

Software or a configuration sequencer fills the table through a plain write port before any lookups are issued. A lookup is started by presenting the two identifier fields with a request strobe while the block is idle. The block visits one node per clock cycle, then emits a single-cycle response with a found flag and the slot. A pair of registers tracks the lowest and highest slot returned by any successful lookup since reset.

Top module: `pid_tree_lookup`

## Requirements
- R1: After reset `busy` and `rsp_valid` are 0, `slot_min` is 0xFF and `slot_max` is 0x00.
- R2: A node word holds the tested bit number in bits [3:0], the one-branch chain flag in bit 4, the one-branch result in bits [12:5], the zero-branch chain flag in bit 13 and the zero-branch result in bits [21:14]. Bits [31:22] are ignored.
- R3: A walk begins at node 0. Each node tests the identifier bit given by its bit number, and bit numbers 12 to 15 read as 0.
- R4: When the taken branch's flag is 1, its result (low 7 bits) is the next node. When the flag is 0, the walk ends with `rsp_found`=1 and `rsp_slot` equal to that result.
- R5: If the 12th node visited still chains onward, the walk ends with `rsp_found`=0 and `rsp_slot`=0.
- R6: A walk that visits k nodes raises `rsp_valid` for exactly one cycle, k clock edges after the edge that accepted the request.
- R7: A request is accepted only when `busy` is 0. `busy` is 1 from the accepting edge until the response edge. A request presented while `busy` is 1 is ignored.
- R8: On a found response, `slot_min` and `slot_max` absorb the slot in the same edge. They change at no other time.
- R9: A table write is visible to every lookup accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Node index to write |
| wr_data | input | 32 | Node word |
| req_valid | input | 1 | Lookup request strobe |
| req_slave | input | 4 | Slave number of the identifier |
| req_periph | input | 8 | Peripheral number of the identifier |
| busy | output | 1 | Walk in progress; requests ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_found | output | 1 | Walk ended on a terminating branch |
| rsp_slot | output | 8 | Resulting slot number |
| slot_min | output | 8 | Lowest slot found since reset |
| slot_max | output | 8 | Highest slot found since reset |

## Verification
A request sampled at an edge raises `busy` at that edge. The response, along with any min/max update, arrives exactly as many edges later as the number of nodes the walk visits: one edge for a root hit and twelve edges for an exhausted walk. The reference model replays the walk on its own copy of the table to predict that count. It then counts down one edge at a time. Outputs are compared with the model at every falling edge, so any early, late, doubled or missing response is reported in the cycle it occurs.

// File: rtl/pid_tree_lookup.sv
module pid_tree_lookup #(
  parameter int SID_W       = 4,
  parameter int PER_W       = 8,
  parameter int SEL_W       = 4,
  parameter int SLOT_W      = 8,
  parameter int WORD_W      = 32,
  parameter int TABLE_DEPTH = 128,
  parameter int MAX_DEPTH   = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(TABLE_DEPTH)-1:0] wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  input  logic                           req_valid,
  input  logic [SID_W-1:0]               req_slave,
  input  logic [PER_W-1:0]               req_periph,
  output logic                           busy,
  output logic                           rsp_valid,
  output logic                           rsp_found,
  output logic [SLOT_W-1:0]              rsp_slot,
  output logic [SLOT_W-1:0]              slot_min,
  output logic [SLOT_W-1:0]              slot_max
);
  localparam int ID_W      = SID_W + PER_W;
  localparam int EXT_W     = 2 ** SEL_W;
  localparam int IDX_W     = $clog2(TABLE_DEPTH);
  localparam int STEP_W    = $clog2(MAX_DEPTH);
  localparam int NODE_W    = SEL_W + 2 * (1 + SLOT_W);
  localparam int ONE_FLAG  = SEL_W;
  localparam int ONE_LO    = SEL_W + 1;
  localparam int ZERO_FLAG = ONE_LO + SLOT_W;
  localparam int ZERO_LO   = ZERO_FLAG + 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_DEPTH - 1);

  logic [NODE_W-1:0] tab [TABLE_DEPTH];
  logic [ID_W-1:0]   id_q;
  logic [IDX_W-1:0]  node_idx;
  logic [STEP_W-1:0] step;
  logic [NODE_W-1:0] node;
  logic [EXT_W-1:0]  id_ext;
  logic              bit_v, take_flag;
  logic [SLOT_W-1:0] take_res;
  logic              unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:NODE_W];

  always_ff @(posedge clk)
    if (wr_en) tab[wr_addr] <= wr_data[NODE_W-1:0];

  assign node      = tab[node_idx];
  assign id_ext    = {{(EXT_W - ID_W){1'b0}}, id_q};
  assign bit_v     = id_ext[node[SEL_W-1:0]];
  assign take_flag = bit_v ? node[ONE_FLAG] : node[ZERO_FLAG];
  assign take_res  = bit_v ? node[ONE_LO +: SLOT_W] : node[ZERO_LO +: SLOT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_slot  <= '0;
      slot_min  <= '1;
      slot_max  <= '0;
      id_q      <= '0;
      node_idx  <= '0;
      step      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          id_q     <= {req_slave, req_periph};
          node_idx <= '0;
          step     <= '0;
        end
      end else if (!take_flag) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_found <= 1'b1;
        rsp_slot  <= take_res;
        if (take_res < slot_min) slot_min <= take_res;
        if (take_res > slot_max) slot_max <= take_res;
      end else if (step == LAST_STEP) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_found <= 1'b0;
        rsp_slot  <= '0;
      end else begin
        node_idx <= take_res[IDX_W-1:0];
        step     <= step + 1'b1;
      end
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R7
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy); // R7
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= LAST_STEP)); // R5
  AST_RANGE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_found) |-> (slot_min <= rsp_slot && slot_max >= rsp_slot)); // R8
  AST_RANGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_found) |-> ($stable(slot_min) && $stable(slot_max))); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_slot == '0)); // R5
endmodule

// File: tb/tb_pid_tree_lookup.sv
module tb_pid_tree_lookup;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic       req_valid = 1'b0;
  logic [3:0] req_slave = '0;
  logic [7:0] req_periph = '0;
  logic       busy, rsp_valid, rsp_found;
  logic [7:0] rsp_slot, slot_min, slot_max;

  always #4 clk = ~clk;

  pid_tree_lookup dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_slave(req_slave), .req_periph(req_periph),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_slot(rsp_slot),
    .slot_min(slot_min), .slot_max(slot_max));

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string slot_tag = "R3";

  logic [31:0] mtab [128];
  int  e_busy = 0, e_rv = 0, e_found = 0, e_slot = 0, e_min = 255, e_max = 0;
  int  cnt = 0, p_found = 0, p_slot = 0;

  function automatic logic [31:0] mk(int sel, int of, int ores, int zf, int zres);
    return 32'(sel) | (32'(of) << 4) | (32'(ores) << 5) | (32'(zf) << 13) | (32'(zres) << 14);
  endfunction

  // Behavioural walk: returns nodes visited; sets found and slot
  task automatic walk(input int id, output int steps, output int f, output int s);
    int idx = 0;
    steps = 12; f = 0; s = 0;
    for (int d = 0; d < 12; d++) begin
      logic [31:0] w = mtab[idx];
      int sel = int'(w[3:0]);
      int b = (sel < 12) ? ((id >> sel) & 1) : 0;
      int fl = b ? int'(w[4]) : int'(w[13]);
      int r  = b ? int'(w[12:5]) : int'(w[21:14]);
      if (fl == 0) begin steps = d + 1; f = 1; s = r; return; end
      idx = r & 127;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy = 0; e_rv = 0; e_found = 0; e_slot = 0; e_min = 255; e_max = 0; cnt = 0;
    end else begin
      int st, f, s;
      e_rv = 0;
      if (wr_en) mtab[wr_addr] = wr_data;
      if (e_busy == 0) begin
        if (req_valid) begin
          walk({req_slave, req_periph}, st, f, s);
          cnt = st; p_found = f; p_slot = s; e_busy = 1;
        end
      end else begin
        cnt--;
        if (cnt == 0) begin
          e_busy = 0; e_rv = 1; e_found = p_found; e_slot = p_slot;
          if (p_found != 0) begin
            if (p_slot < e_min) e_min = p_slot;
            if (p_slot > e_max) e_max = p_slot;
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      chk("R1", "slot_min", int'(slot_min), 255);
      chk("R1", "slot_max", int'(slot_max), 0);
    end else begin
      chk("R7", "busy", int'(busy), e_busy);
      chk("R6", "rsp_valid", int'(rsp_valid), e_rv);
      if (e_rv != 0) begin
        chk(e_found != 0 ? "R4" : "R5", "rsp_found", int'(rsp_found), e_found);
        chk(slot_tag, "rsp_slot", int'(rsp_slot), e_slot);
      end
      chk("R8", "slot_min", int'(slot_min), e_min);
      chk("R8", "slot_max", int'(slot_max), e_max);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(int sl, int pe);
    @(negedge clk);
    req_valid = 1'b1; req_slave = 4'(sl); req_periph = 8'(pe);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: node layout, upper bits set to show they are ignored
    wr(0, mk(11, 0, 8'h80, 1, 1) | 32'hFFC0_0000);
    wr(1, mk(0, 1, 2, 0, 8'h05));
    wr(2, mk(8, 0, 8'h20, 1, 4));
    wr(3, mk(0, 1, 3, 1, 3));
    wr(4, mk(14, 0, 8'hEE, 1, 3));
    slot_tag = "R2";
    lookup(8, 8'h00);
    slot_tag = "R3";
    lookup(0, 8'h02);
    lookup(1, 8'h01);
    lookup(0, 8'h03);
    lookup(15, 8'hFF);
    // R7: hold a different request while the walk is busy
    @(negedge clk);
    req_valid = 1'b1; req_slave = 4'h1; req_periph = 8'h01;
    @(negedge clk);
    req_slave = 4'h0; req_periph = 8'h02;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (14) @(negedge clk);
    // R9: rewrite root, then look up again
    wr(0, mk(11, 0, 8'hF0, 1, 1));
    slot_tag = "R9";
    lookup(8, 8'h00);
    lookup(0, 8'h00);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule